// File: doc/BRIEF.md
# Serial Control Word Receiver for an Audio Front End

This block is the write-only digital control port of a mixed-signal audio front end. An external controller sends 16-bit control words over three wires: an active-low select, a serial clock and a data line. The block oversamples the three wires with its own system clock, shifts in one word per select window, least significant bit first, and, when the select line returns high after exactly sixteen serial clock rising edges, updates a control register. That register drives the power enables of the record, line, microphone, level-control and speaker amplifiers. It also drives the line mute, a two-bit automatic level-control target code and a five-bit volume code for the attenuator.

After reset the block produces an internal power-on pulse. While the pulse is active and for some time after it, the outputs stay at their defaults. The first good word that completes after the pulse is parked in a holding register. It reaches the outputs only on the next select rising edge, which ends the start-up condition. From then on, every good word takes effect when its select window closes.

A standby input is applied on top of the register. It turns off every amplifier except the speaker amplifier without changing the stored word.

Top module: `audio_ctl_port`

## Requirements
- R1: Data is taken on serial clock rising edges while select is low, least significant bit first. The first bit sent lands in word bit 0 and the sixteenth lands in bit 15.
- R2: Word bits 8..4 drive `vol_code[4:0]`, with bit 4 as weight 1 and bit 8 as weight 16. Code 31 is full volume and code 0 is mute.
- R3: Word bit 0 controls the record amplifier, bit 1 the line amplifier, bit 3 the speaker, bit 12 the microphone amplifier and bit 13 the level-control amplifier. A bit of 0 drives the matching enable output high and a bit of 1 drives it low.
- R4: Word bit 2 controls the line mute. A 0 drives `line_mute` high and a 1 drives it low.
- R5: Word bits 15..14 drive `alc_lvl[1:0]` unchanged. Code 00 selects +10 dB, code 01 (bit 14 set) selects +12 dB and code 10 (bit 15 set) selects +14 dB.
- R6: After reset the outputs show the default word 0x0080: all enables high, `line_mute` high, `vol_code` 8 and `alc_lvl` 00. They keep these values until the second select rising edge that follows the end of the power-on pulse.
- R7: The first good word that completes after the pulse is held. It is applied at the second select rising edge, and the content of the frame that ends at that edge is not applied.
- R8: After start-up, a frame with exactly 16 serial clock rising edges updates all outputs from its word once select rises.
- R9: A frame with any other number of serial clock rising edges (0, 15 or 17, for example) leaves all outputs unchanged.
- R10: While `stby` is high, `rec_en`, `line_en`, `mic_en` and `alc_en` are low. `spk_en`, `line_mute`, `vol_code` and `alc_lvl` are unaffected, and the stored word returns to the outputs when `stby` falls.
- R11: Word bits 11..9 have no effect, and serial clock edges while select is high are ignored.
- R12: Select rising edges that occur while the power-on pulse is active do not count toward the start-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low; its rising edge ends a frame |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| stby | input | 1 | Standby; high turns off all amplifiers except the speaker |
| rec_en | output | 1 | Record amplifier enable |
| line_en | output | 1 | Line amplifier enable |
| line_mute | output | 1 | Line output mute |
| spk_en | output | 1 | Speaker amplifier enable |
| mic_en | output | 1 | Microphone amplifier enable |
| alc_en | output | 1 | Level-control amplifier enable |
| alc_lvl | output | 2 | Level-control target code |
| vol_code | output | 5 | Attenuator volume code |

## Verification
The bench walks through the start-up sequence, including a select pulse that falls inside the power-on pulse. A design that counted that pulse, or that applied the second word instead of the held first one, would leave the outputs at the wrong word after start-up. It sweeps all 32 volume codes and all 64 combinations of the six switch bits. A bit-order or field-offset error shows up there as a swapped or shifted field. Frames of 0, 15 and 17 edges, stray serial clock edges while select is high, dummy-bit changes and standby with all amplifiers on are each sent and checked. A design that loaded a short frame, counted idle clocks, decoded dummy bits or let standby reach the speaker or the stored word would show a changed output.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

  localparam int WORD_W = 16;

  // field positions (decoded by the register)
  localparam int B_REC  = 0;
  localparam int B_LINE = 1;
  localparam int B_MUTE = 2;
  localparam int B_SPK  = 3;
  localparam int B_VOL  = 4;
  localparam int VOL_W  = 5;
  localparam int B_MIC  = 12;
  localparam int B_ALC  = 13;
  localparam int B_LVL  = 14;

  localparam logic [WORD_W-1:0] DEFAULT_WORD = 16'h0080;

  typedef enum logic [1:0] {
    ST_PULSE = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2,
    ST_RUN   = 2'd3
  } stage_t;

  typedef struct packed {
    logic [1:0]       lvl;
    logic             alc_off;
    logic             mic_off;
    logic [VOL_W-1:0] vol;
    logic             spk_off;
    logic             mute_off;
    logic             line_off;
    logic             rec_off;
  } ctl_t;

endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_l,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q    = chain_q[STAGES-1];
  assign rise = q & ~prev_q;
  assign fall = ~q & prev_q;

endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              sel_act,
  input  logic              sel_fall,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              full
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              take;

  assign take = sel_act & sclk_rise;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (sel_fall) begin
      cnt_d = '0;
    end else if (take) begin
      sh_d = {din, sh_q[WORD_W-1:1]};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign word = sh_q;
  assign full = (cnt_q == CNT_FULL);

  // R9: counter saturates one past a full word
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_l)
    cnt_q <= CNT_OVER);

  // R1: newest bit enters at the top, so the first bit ends in bit 0
  p_lsb_first_r1: assert property (@(posedge clk) disable iff (!rst_l)
    (take && !sel_fall) |=> sh_q[WORD_W-1] == $past(din));

endmodule

// File: rtl/por_seq.sv
module por_seq
  import audio_ctl_pkg::*;
#(
  parameter int POR_CYCLES = 16
) (
  input  logic   clk,
  input  logic   rst_l,
  input  logic   cs_rise,
  output stage_t stage
);

  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [PW-1:0] P_END = PW'(POR_CYCLES);

  logic [PW-1:0] pcnt_q, pcnt_d;
  stage_t        st_q, st_d;

  always_comb begin
    pcnt_d = pcnt_q;
    st_d   = st_q;
    if (pcnt_q != P_END) pcnt_d = pcnt_q + 1'b1;
    case (st_q)
      ST_PULSE: if (pcnt_q == P_END) st_d = ST_WAIT1;
      ST_WAIT1: if (cs_rise) st_d = ST_WAIT2;
      ST_WAIT2: if (cs_rise) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      pcnt_q <= '0;
      st_q   <= ST_PULSE;
    end else begin
      pcnt_q <= pcnt_d;
      st_q   <= st_d;
    end
  end

  assign stage = st_q;

  // R6: stages only advance one step at a time
  p_stage_order_r6: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q != $past(st_q)) |-> (st_q == stage_t'($past(st_q) + 2'd1)));

  // R12: a select edge during the pulse never advances past the pulse
  p_pulse_ignore_r12: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_PULSE && pcnt_q != P_END && cs_rise) |=> st_q == ST_PULSE);

endmodule

// File: rtl/audio_ctl_port.sv
module audio_ctl_port
  import audio_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_sel_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       stby,
  output logic       rec_en,
  output logic       line_en,
  output logic       line_mute,
  output logic       spk_en,
  output logic       mic_en,
  output logic       alc_en,
  output logic [1:0] alc_lvl,
  output logic [4:0] vol_code
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  // pin synchronizers
  logic sel_q, sel_rise, sel_fall;
  logic sclk_q, sclk_rise, sclk_fall;
  logic dat_q, dat_rise, dat_fall;

  ser_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel (
    .clk(clk), .rst_l(rst_l), .d(ser_sel_n),
    .q(sel_q), .rise(sel_rise), .fall(sel_fall));

  ser_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_l(rst_l), .d(ser_clk),
    .q(sclk_q), .rise(sclk_rise), .fall(sclk_fall));

  ser_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dat (
    .clk(clk), .rst_l(rst_l), .d(ser_dat),
    .q(dat_q), .rise(dat_rise), .fall(dat_fall));

  logic unused_pins;
  assign unused_pins = sclk_q ^ sclk_fall ^ dat_rise ^ dat_fall;

  // shifter
  logic [WORD_W-1:0] sh_word;
  logic              sh_full;

  frame_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_l(rst_l), .sel_act(~sel_q), .sel_fall(sel_fall),
    .sclk_rise(sclk_rise), .din(dat_q), .word(sh_word), .full(sh_full));

  // start-up sequencer
  stage_t stage;

  por_seq #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst_l(rst_l), .cs_rise(sel_rise), .stage(stage));

  // field extraction (dummy bits 11..9 dropped)
  ctl_t word_ctl;
  logic unused_dummy;

  always_comb begin
    word_ctl.rec_off  = sh_word[B_REC];
    word_ctl.line_off = sh_word[B_LINE];
    word_ctl.mute_off = sh_word[B_MUTE];
    word_ctl.spk_off  = sh_word[B_SPK];
    word_ctl.vol      = sh_word[B_VOL +: VOL_W];
    word_ctl.mic_off  = sh_word[B_MIC];
    word_ctl.alc_off  = sh_word[B_ALC];
    word_ctl.lvl      = sh_word[B_LVL +: 2];
  end
  assign unused_dummy = ^sh_word[B_MIC-1:B_VOL+VOL_W];

  localparam ctl_t DEF_CTL = '{
    lvl:      DEFAULT_WORD[B_LVL +: 2],
    alc_off:  DEFAULT_WORD[B_ALC],
    mic_off:  DEFAULT_WORD[B_MIC],
    vol:      DEFAULT_WORD[B_VOL +: VOL_W],
    spk_off:  DEFAULT_WORD[B_SPK],
    mute_off: DEFAULT_WORD[B_MUTE],
    line_off: DEFAULT_WORD[B_LINE],
    rec_off:  DEFAULT_WORD[B_REC]
  };

  // hold and output registers
  ctl_t hold_q, hold_d;
  ctl_t ctl_q, ctl_d;
  logic hold_we, ctl_we;

  always_comb begin
    hold_we = 1'b0;
    ctl_we  = 1'b0;
    hold_d  = word_ctl;
    ctl_d   = word_ctl;
    if (sel_rise) begin
      case (stage)
        ST_WAIT1: hold_we = sh_full;
        ST_WAIT2: begin ctl_we = 1'b1; ctl_d = hold_q; end
        ST_RUN:   ctl_we = sh_full;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      hold_q <= DEF_CTL;
      ctl_q  <= DEF_CTL;
    end else begin
      if (hold_we) hold_q <= hold_d;
      if (ctl_we)  ctl_q  <= ctl_d;
    end
  end

  // output decode with standby override
  assign rec_en    = ~ctl_q.rec_off  & ~stby;
  assign line_en   = ~ctl_q.line_off & ~stby;
  assign mic_en    = ~ctl_q.mic_off  & ~stby;
  assign alc_en    = ~ctl_q.alc_off  & ~stby;
  assign spk_en    = ~ctl_q.spk_off;
  assign line_mute = ~ctl_q.mute_off;
  assign vol_code  = ctl_q.vol;
  assign alc_lvl   = ctl_q.lvl;

  // R6: defaults persist until start-up completes
  p_default_until_run_r6: assert property (@(posedge clk) disable iff (!rst_l)
    (stage != ST_RUN) |-> (ctl_q == DEF_CTL));

  // R10: standby keeps the non-speaker amplifiers off
  p_standby_off_r10: assert property (@(posedge clk) disable iff (!rst_l)
    stby |-> !(rec_en || line_en || mic_en || alc_en));

  // R9: an incomplete or overlong frame leaves the register alone
  p_bad_frame_keep_r9: assert property (@(posedge clk) disable iff (!rst_l)
    (sel_rise && !sh_full && stage == ST_RUN) |=> $stable(ctl_q));

  // R8: a good frame in normal operation lands in the register
  p_good_frame_r8: assert property (@(posedge clk) disable iff (!rst_l)
    (sel_rise && sh_full && stage == ST_RUN) |=> ctl_q == $past(word_ctl));

  // R7: the held word is what start-up releases
  p_hold_release_r7: assert property (@(posedge clk) disable iff (!rst_l)
    (sel_rise && stage == ST_WAIT2) |=> ctl_q == $past(hold_q));

endmodule

// File: tb/sim_audio_ctl_port.sv
module sim_audio_ctl_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, sclk = 1'b0, sdat = 1'b0, stby = 1'b0;
  logic       rec_en, line_en, line_mute, spk_en, mic_en, alc_en;
  logic [1:0] alc_lvl;
  logic [4:0] vol_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int HB = 4;

  always #2 clk = ~clk;   // 250 MHz

  audio_ctl_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sclk),
    .ser_dat(sdat), .stby(stby), .rec_en(rec_en), .line_en(line_en),
    .line_mute(line_mute), .spk_en(spk_en), .mic_en(mic_en),
    .alc_en(alc_en), .alc_lvl(alc_lvl), .vol_code(vol_code));

  // expected output vector {rec,line,mute,spk,mic,alc,lvl[1:0],vol[4:0]}
  function automatic logic [12:0] expect_of(input logic [15:0] w, input logic sb);
    return {~w[0] & ~sb, ~w[1] & ~sb, ~w[2], ~w[3], ~w[12] & ~sb,
            ~w[13] & ~sb, w[15:14], w[8:4]};
  endfunction

  task automatic check(input string tag, input logic [15:0] w);
    logic [12:0] act, exp;
    @(negedge clk);
    act = {rec_en, line_en, line_mute, spk_en, mic_en, alc_en, alc_lvl, vol_code};
    exp = expect_of(w, stby);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (word %h)", tag, act, exp, w);
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    @(negedge clk);
    sel_n = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdat = w[i % 16];
      repeat (HB) @(negedge clk);
      sclk = 1'b1;
      repeat (HB) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HB) @(negedge clk);
    sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    logic [15:0] cur;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: select pulse inside the power-on pulse
    repeat (2) @(negedge clk);
    sel_n = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b1;
    repeat (40) @(negedge clk);
    check("R6 reset defaults", 16'h0080);

    // R7: first frame held, second frame content discarded
    send(16'h6A5B, 16);
    check("R6 defaults after first frame", 16'h0080);
    send(16'h9123, 16);
    check("R7 held first word applied (R12 pulse not counted)", 16'h6A5B);

    // R8: normal frame
    send(16'h0000, 16);
    check("R8 all-on word", 16'h0000);
    cur = 16'h0000;

    // R1/R2: volume sweep
    for (int v = 0; v < 32; v++) begin
      w = 16'(v) << 4;
      send(w, 16);
      check("R2 R1 volume sweep", w);
    end

    // R3/R4: all switch combinations
    for (int p = 0; p < 64; p++) begin
      w = 16'h0000;
      w[0] = p[0]; w[1] = p[1]; w[2] = p[2]; w[3] = p[3];
      w[12] = p[4]; w[13] = p[5];
      w[8:4] = 5'(p) ^ 5'h15;
      send(w, 16);
      check("R3 R4 switch sweep", w);
    end

    // R5: level codes
    for (int l = 0; l < 4; l++) begin
      w = {2'(l), 14'h0120};
      send(w, 16);
      check("R5 level code", w);
    end
    cur = w;

    // R9: wrong lengths
    send(16'hFFFF, 15);
    check("R9 15-edge frame ignored", cur);
    send(16'hFFFF, 17);
    check("R9 17-edge frame ignored", cur);
    send(16'hFFFF, 0);
    check("R9 empty frame ignored", cur);

    // R11: dummy bits and idle clocks
    send(16'h00C0, 16);
    check("R8 reload", 16'h00C0);
    send(16'h0EC0, 16);
    check("R11 dummy bits no effect", 16'h00C0);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; repeat (HB) @(negedge clk);
      sclk = 1'b0; repeat (HB) @(negedge clk);
    end
    check("R11 idle clocks no effect", 16'h00C0);
    send(16'h4031, 16);
    check("R11 frame after idle clocks", 16'h4031);

    // R10: standby
    send(16'h0000, 16);
    stby = 1'b1;
    check("R10 standby forces off", 16'h0000);
    send(16'h8008, 16);
    check("R10 standby with new word", 16'h8008);
    stby = 1'b0;
    check("R10 standby released", 16'h8008);

    // R6 again after a fresh reset
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 defaults in reset", 16'h0080);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    send(16'h0000, 16);
    check("R6 first frame not applied", 16'h0080);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule